// File: doc/BRIEF.md
# Unary Bit-Stream Sorting Network

This block sorts eight small unsigned numbers by turning each of them into a unary bit-stream and passing the streams through a fixed network of compare-and-swap nodes. In a unary stream a value is a run of ones followed by a run of zeros, and the value equals the number of ones. Against such streams the minimum of two values is the AND of their bits and the maximum is the OR. A node is therefore two gates, not a magnitude comparator with two multiplexers. The price is time: a W-bit value takes 2^W cycles to stream through, one bit per cycle.

A caller presents eight W-bit binary values on a flat input bus and pulses `start`. An internal generator turns each value into a stream. A bitonic network of 24 two-gate nodes orders the streams, which leave on eight serial output lines, lowest lane smallest. A bank of counters converts each sorted stream back to binary and raises `done` when the last bit has been counted. The network wiring is fixed at elaboration and never depends on the data.

Top module: `uns_sorter`

## Requirements
- R1: During stream cycle k (k = 0 to 2^W-1, counting from the accepted start), the stream of a value v carries a 1 exactly when k < v.
- R2: Output lane 0 carries the smallest value and lane 7 the largest. Lane j of `sums_out` occupies bits [j*W +: W], and lane i of `vals_in` occupies bits [i*W +: W].
- R3: With the output register enabled (default), the output bit of stream cycle k appears on `stream_out` after clock edge k+1, counted from the edge that accepted `start` as edge 0.
- R4: `busy` is high for exactly 2^W cycles after an accepted start. `done` rises after edge 2^W, in the same cycle `busy` falls, and `busy` and `done` are never high together.
- R5: When `done` rises, each lane of `sums_out` equals the number of ones in the matching output stream, which is the sorted input value.
- R6: `done` stays high and `sums_out` stays unchanged until the next accepted start. `sums_out` keeps the previous result during the following run, until that run completes.
- R7: A `start` pulse that arrives while `busy` is high is ignored: neither the values nor the cycle count are reloaded.
- R8: Values of 0 and 2^W-1, and repeated values, sort correctly.
- R9: After reset, `busy`, `done`, `stream_out` and `sums_out` are all zero.
- R10: In every cycle the output bits are ordered across lanes: when lane j carries a 1, lane j+1 also carries a 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sort; sampled only while idle |
| vals_in | input | LANES*W | Eight binary values, lane i at [i*W +: W] |
| busy | output | 1 | Streams in flight |
| done | output | 1 | Result valid; held until next accepted start |
| stream_out | output | LANES | Sorted serial streams, one bit per lane per cycle |
| sums_out | output | LANES*W | Sorted binary values, lane j at [j*W +: W] |

## Verification
A wrong node orientation or a crossed wire breaks the lane ordering of the output bits within the first stream cycle whose bits differ, one edge after that cycle. A miscounted stream counter only shows up in `sums_out` when `done` rises, 2^W cycles after the start. A sequencer that restarts on a stray start pulse delays `done` past the expected edge, and a sequencer that reloads the values changes the result at that edge. The bench therefore compares every output bit in every stream cycle, and also checks the completion edge and the held result.

// File: rtl/uns_pkg.sv
package uns_pkg;

   // Number of compare layers in a bitonic network over 2**lg lanes.
   function automatic int unsigned net_stages(input int unsigned lg);
      return (lg * (lg + 1)) / 2;
   endfunction

   // Number of two-gate nodes in that network.
   function automatic int unsigned net_nodes(input int unsigned lg);
      return net_stages(lg) * ((1 << lg) / 2);
   endfunction

endpackage

// File: rtl/uns_cas.sv
module uns_cas #(
   parameter bit ASC = 1'b1
) (
   input  logic a,
   input  logic b,
   input  logic lo,
   output logic out_lo,
   output logic out_hi
);
   // lo is a spare tie-off pin kept unused by design intent of uniform wiring
   logic mn, mx;
   assign mn = a & b;
   assign mx = a | b;

   if (ASC) begin : g_up
      assign out_lo = mn;
      assign out_hi = mx;
   end else begin : g_down
      assign out_lo = mx;
      assign out_hi = mn;
   end

   logic unused_lo;
   assign unused_lo = lo;
endmodule

// File: rtl/uns_seq.sv
module uns_seq #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   output logic         accept,
   output logic         active,
   output logic         last,
   output logic [W-1:0] phase,
   output logic         done
);
   localparam logic [W-1:0] PH_MAX = {W{1'b1}};

   assign accept = start & ~active;
   assign last   = active & (phase == PH_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         phase  <= '0;
         done   <= 1'b0;
      end else if (accept) begin
         active <= 1'b1;
         phase  <= '0;
         done   <= 1'b0;
      end else if (active) begin
         if (last) begin
            active <= 1'b0;
            phase  <= '0;
            done   <= 1'b1;
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end
endmodule

// File: rtl/uns_gen.sv
module uns_gen #(
   parameter int LANES = 8,
   parameter int W     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               active,
   input  logic [W-1:0]       phase,
   input  logic [LANES*W-1:0] vals,
   output logic [LANES-1:0]   bits
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [W-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    val_q <= '0;
         else if (load) val_q <= vals[i*W +: W];
      end
      assign bits[i] = active & (phase < val_q);
   end
endmodule

// File: rtl/uns_net.sv
module uns_net #(
   parameter int LOG_LANES = 3,
   localparam int LANES = 1 << LOG_LANES
) (
   input  logic [LANES-1:0] in_bits,
   output logic [LANES-1:0] out_bits
);
   localparam int NST = uns_pkg::net_stages(LOG_LANES);

   logic [NST:0][LANES-1:0] lv;

   assign lv[0]    = in_bits;
   assign out_bits = lv[NST];

   for (genvar kk = 1; kk <= LOG_LANES; kk++) begin : g_blk
      for (genvar jx = 0; jx < kk; jx++) begin : g_dist
         localparam int SI = (kk * (kk - 1)) / 2 + jx;
         localparam int JJ = kk - 1 - jx;
         localparam int D  = 1 << JJ;
         for (genvar ii = 0; ii < LANES; ii++) begin : g_lane
            if ((ii & D) == 0) begin : g_node
               localparam bit ASC = (((ii >> kk) & 1) == 0);
               uns_cas #(.ASC(ASC)) u_cas (
                  .a      (lv[SI][ii]),
                  .b      (lv[SI][ii+D]),
                  .lo     (1'b0),
                  .out_lo (lv[SI+1][ii]),
                  .out_hi (lv[SI+1][ii+D])
               );
            end
         end
      end
   end
endmodule

// File: rtl/uns_tally.sv
module uns_tally #(
   parameter int LANES = 8,
   parameter int W     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               active,
   input  logic               last,
   input  logic [LANES-1:0]   bits,
   output logic [LANES*W-1:0] sums
);
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [W-1:0] acc;
      logic [W-1:0] nxt;
      logic [W-1:0] res_q;
      assign nxt = acc + {{(W-1){1'b0}}, bits[j]};
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc   <= '0;
            res_q <= '0;
         end else begin
            if (clear)       acc <= '0;
            else if (active) acc <= nxt;
            if (last)        res_q <= nxt;
         end
      end
      assign sums[j*W +: W] = res_q;
   end
endmodule

// File: rtl/uns_sorter.sv
module uns_sorter #(
   parameter int LOG_LANES = 3,
   parameter int W         = 4,
   parameter bit OUT_REG   = 1'b1,
   localparam int LANES    = 1 << LOG_LANES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LANES*W-1:0] vals_in,
   output logic               busy,
   output logic               done,
   output logic [LANES-1:0]   stream_out,
   output logic [LANES*W-1:0] sums_out
);
   if (LOG_LANES < 1 || LOG_LANES > 6) begin : g_bad_lanes
      $error("uns_sorter: LOG_LANES out of range");
   end
   if (W < 1 || W > 16) begin : g_bad_width
      $error("uns_sorter: W out of range");
   end

   logic         accept, active, last;
   logic [W-1:0] phase;
   logic [LANES-1:0] gen_bits, net_bits;

   uns_seq #(.W(W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
      .active(active), .last(last), .phase(phase), .done(done)
   );

   uns_gen #(.LANES(LANES), .W(W)) u_gen (
      .clk(clk), .rst_n(rst_n), .load(accept), .active(active),
      .phase(phase), .vals(vals_in), .bits(gen_bits)
   );

   uns_net #(.LOG_LANES(LOG_LANES)) u_net (
      .in_bits(gen_bits), .out_bits(net_bits)
   );

   uns_tally #(.LANES(LANES), .W(W)) u_tally (
      .clk(clk), .rst_n(rst_n), .clear(accept), .active(active),
      .last(last), .bits(net_bits), .sums(sums_out)
   );

   if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stream_out <= '0;
         else        stream_out <= net_bits;
      end
   end else begin : g_ocomb
      assign stream_out = net_bits;
   end

   assign busy = active;
endmodule

// File: rtl/uns_sorter_chk.sv
module uns_sorter_chk #(
   parameter int LANES = 8,
   parameter int W     = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic [LANES-1:0]   stream_out,
   input logic [LANES*W-1:0] sums_out
);
   localparam int LEN = 1 << W;

   logic [W+1:0] cnt;
   logic         sums_ordered;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cnt <= '0;
      else if (start && !busy)                   cnt <= 1;
      else if (cnt != 0 && cnt <= (W+2)'(LEN))   cnt <= cnt + 1'b1;
   end

   always_comb begin
      sums_ordered = 1'b1;
      for (int j = 0; j < LANES - 1; j++)
         if (sums_out[j*W +: W] > sums_out[(j+1)*W +: W]) sums_ordered = 1'b0;
   end

   AST_DONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> cnt == (W+2)'(LEN + 1));                          // R4
   AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));                                                  // R4
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt >= 1 && cnt <= (W+2)'(LEN)) |-> busy);                        // R7
   AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (stream_out[LANES-2:0] & ~stream_out[LANES-1:1]) == '0);           // R10
   AST_SUMS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> sums_ordered);                                            // R2
   AST_SUMS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> $stable(sums_out));                      // R6
endmodule

bind uns_sorter uns_sorter_chk #(.LANES(LANES), .W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .stream_out(stream_out), .sums_out(sums_out)
);

// File: tb/sim_uns_sorter.sv
`timescale 1ns/1ps
module sim_uns_sorter;
   localparam int L  = 8;
   localparam int W  = 4;
   localparam int LN = 1 << W;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [L*W-1:0] vals_in = '0;
   logic           busy, done;
   logic [L-1:0]   stream_out;
   logic [L*W-1:0] sums_out;
   logic [L*W-1:0] prev_sums = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   uns_sorter #(.LOG_LANES(3), .W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .vals_in(vals_in),
      .busy(busy), .done(done), .stream_out(stream_out), .sums_out(sums_out)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [L*W-1:0] pack(input int v[L]);
      logic [L*W-1:0] r;
      r = '0;
      for (int i = 0; i < L; i++) r[i*W +: W] = W'(v[i]);
      return r;
   endfunction

   task automatic sort8(input int v[L], output int s[L]);
      int t;
      s = v;
      for (int i = 1; i < L; i++)
         for (int j = i; j > 0 && s[j-1] > s[j]; j--) begin
            t = s[j]; s[j] = s[j-1]; s[j-1] = t;
         end
   endtask

   // One full sort; optionally pulses start again mid-run (R7).
   task automatic run_sort(input int v[L], input bit intrude);
      int s[L];
      int junk[L];
      logic [L-1:0] exp_bits;
      logic [L*W-1:0] exp_sums;
      sort8(v, s);
      for (int i = 0; i < L; i++) junk[i] = LN - 1 - (i % LN);
      @(negedge clk);
      start   = 1'b1;
      vals_in = pack(v);
      @(posedge clk); #1;
      start   = 1'b0;
      vals_in = pack(junk);
      for (int k = 0; k < LN; k++) begin
         @(posedge clk); #1;
         for (int j = 0; j < L; j++) exp_bits[j] = (k < s[j]);
         chk("R1/R3 stream bits", 64'(stream_out), 64'(exp_bits));
         if (k < LN - 1) chk("R4 busy/done mid-run", {busy, done}, 2'b10);
         else            chk("R4 busy/done at end", {busy, done}, 2'b01);
         if (k == 3) chk("R6 previous result held", 64'(sums_out), 64'(prev_sums));
         if (intrude && k == 5) start = 1'b1;
         if (intrude && k == 6) start = 1'b0;
      end
      exp_sums = pack(s);
      chk("R5 sums", 64'(sums_out), 64'(exp_sums));
      prev_sums = exp_sums;
   endtask

   initial begin
      int v[L];
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      #1;
      chk("R9 reset busy/done", {busy, done}, 2'b00);
      chk("R9 reset stream", 64'(stream_out), 64'h0);
      chk("R9 reset sums", 64'(sums_out), 64'h0);
      @(negedge clk); rst_n = 1'b1;

      // R8 all zero
      for (int i = 0; i < L; i++) v[i] = 0;
      run_sort(v, 1'b0);
      // R8 all max
      for (int i = 0; i < L; i++) v[i] = LN - 1;
      run_sort(v, 1'b0);
      // R2 descending
      for (int i = 0; i < L; i++) v[i] = 14 - 2*i;
      run_sort(v, 1'b0);
      // R6 hold after done
      repeat (5) begin
         @(posedge clk); #1;
         chk("R6 done held", 64'(done), 64'h1);
         chk("R6 sums held", 64'(sums_out), 64'(prev_sums));
      end
      // R8 extremes and duplicates mixed
      v = '{15, 0, 7, 15, 0, 7, 1, 14};
      run_sort(v, 1'b0);
      // R7 ignored start during run
      v = '{3, 9, 1, 12, 5, 5, 0, 15};
      run_sort(v, 1'b1);
      // random runs
      for (int r = 0; r < 14; r++) begin
         for (int i = 0; i < L; i++) v[i] = $urandom_range(LN - 1, 0);
         run_sort(v, r[0]);
      end

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule